// File: doc/BRIEF.md
# Machine-Cycle Timer / Falling-Edge Event Counter

This block is a 16-bit up-counter held as two byte registers. A divide-by-12 phase sequencer splits the fast clock into machine cycles of twelve clocks each. In timer mode the counter advances once per machine cycle. In event mode it advances once for each falling edge seen on an external input.

In event mode the input first passes through a two-flop synchroniser. It is then sampled at one fixed phase of every machine cycle. A count is recorded when one sample is high and the next sample is low, and the increment lands one machine cycle after the cycle in which that pair was seen.

Software controls the block with a run bit and a mode bit. It can write either byte at any time, and it clears a sticky overflow flag. Counting stops while the run bit is low. The fastest input the block can count is one edge every 24 clocks.

Top module: `evt_timer16`

## Requirements
- R1: After reset both count bytes read 0x00, the overflow flag is 0, and the sequencer is at phase 0 on the first rising edge after reset is released.
- R2: With `cnt_mode`=0 and `run_en`=1, the 16-bit count rises by exactly 1 once in every 12 clocks. Any 120 consecutive clocks without a write therefore add exactly 10.
- R3: `cnt_lo` is the low byte and `cnt_hi` the high byte of one 16-bit value. An increment from a low byte of 0xFF carries into the high byte.
- R4: With `cnt_mode`=1, the synchronised `ext_in` is sampled once per machine cycle. One count results for each pair of consecutive samples that reads 1 followed by 0.
- R5: An event count becomes visible in the machine cycle that follows the sample that detected it, never in the same machine cycle.
- R6: A high pulse on `ext_in` that no sample captures produces no count, and a steady low input produces no counts.
- R7: With `run_en`=0 the count holds its value in either mode.
- R8: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag`. The flag stays set until a cycle with `clr_ovf`=1, and a set in the same cycle as a clear wins.
- R9: `wr_lo`/`wr_hi` load `wr_data` into the low/high byte on the next clock while the other byte keeps its value. Any byte write cancels an increment that falls in the same cycle, and no overflow is set in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enabled when 1 |
| cnt_mode | input | 1 | 0 = machine-cycle timer, 1 = falling-edge event counter |
| ext_in | input | 1 | Asynchronous event input |
| wr_lo | input | 1 | Load low byte from `wr_data` |
| wr_hi | input | 1 | Load high byte from `wr_data` |
| wr_data | input | 8 | Byte write data |
| clr_ovf | input | 1 | Clear overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Two pairs of events can land on the same clock edge. A byte write can meet the increment phase, and a flag clear can meet a rollover. The bench tracks the machine-cycle phase in its model, so it can hold each write or clear until the clock just before the increment phase and then drive it. In the write case it checks that the written byte holds `wr_data`, the other byte keeps its value and no increment was applied. In the clear case it checks that the flag still reads 1 afterwards.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } cnt_mode_e;

  function automatic int phase_width(input int len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction
endpackage

// File: rtl/mcyc_seq.sv
module mcyc_seq #(
  parameter int MC_LEN = 12,
  parameter int SMP_PH = 9,
  parameter int INC_PH = 2,
  localparam int PH_W = evt_timer_pkg::phase_width(MC_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            smp_stb,
  output logic            inc_stb
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_LEN - 1);
  localparam logic [PH_W-1:0] SMP_P   = PH_W'(SMP_PH);
  localparam logic [PH_W-1:0] INC_P   = PH_W'(INC_PH);

  always_ff @(posedge clk) begin
    if (rst)                 phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign smp_stb = (phase == SMP_P);
  assign inc_stb = (phase == INC_P);

  // R2: the increment strobe is a single-clock pulse per machine cycle
  p_inc_single_r2: assert property (@(posedge clk) disable iff (rst)
    inc_stb |=> !inc_stb);
  // R1: phase sequence wraps back to 0
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST_PH) |=> (phase == '0));
endmodule

// File: rtl/edge_sampler.sv
module edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic smp_stb,
  output logic fall_det
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_smp;
  logic                   sync_out;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_smp <= 1'b0;
      fall_det <= 1'b0;
    end else if (smp_stb) begin
      fall_det <= last_smp & ~sync_out;
      last_smp <= sync_out;
    end
  end

  // R4: the detect flag only changes right after a sampling phase
  p_det_at_sample_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(fall_det) |-> $past(smp_stb));
  // R6: a low-then-anything pair never raises detection
  p_no_det_from_low_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !last_smp) |=> !fall_det);
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [NBYTES-1:0] wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr_ovf,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  logic [BYTE_W-1:0] byte_q [NBYTES];
  logic [NBYTES:0]   carry;
  logic              any_wr;
  logic              ovf_set;

  assign any_wr   = |wr_en;
  assign carry[0] = 1'b1;

  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign carry[i+1] = carry[i] & (&byte_q[i]);
      assign cnt[i*BYTE_W +: BYTE_W] = byte_q[i];

      always_ff @(posedge clk) begin
        if (rst)                 byte_q[i] <= '0;
        else if (any_wr) begin
          if (wr_en[i])          byte_q[i] <= wr_data;
        end
        else if (inc && carry[i]) byte_q[i] <= byte_q[i] + 1'b1;
      end

      // R9: a byte write lands on the next clock
      p_byte_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en[i] |=> (byte_q[i] == $past(wr_data)));
    end
  endgenerate

  assign ovf_set = inc & ~any_wr & carry[NBYTES];

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (ovf_set) ovf <= 1'b1;
    else if (clr_ovf) ovf <= 1'b0;
  end

  // R8: rollover from all-ones gives zero and raises the flag
  p_rollover_r8: assert property (@(posedge clk) disable iff (rst)
    (inc && !any_wr && cnt == {CNT_W{1'b1}}) |=> (ovf && cnt == '0));
  // R7: without increment or write the count holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !any_wr) |=> $stable(cnt));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int BYTE_W      = 8,
  parameter int MC_LEN      = 12,
  parameter int SMP_PH      = 9,
  parameter int INC_PH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              cnt_mode,
  input  logic              ext_in,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr_ovf,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag
);
  import evt_timer_pkg::*;

  localparam int NBYTES = 2;
  localparam int CNT_W  = BYTE_W * NBYTES;
  localparam int PH_W   = phase_width(MC_LEN);

  logic [PH_W-1:0]  phase;
  logic             smp_stb, inc_stb, fall_det, inc;
  logic [CNT_W-1:0] cnt;
  cnt_mode_e        mode;

  assign mode = cnt_mode_e'(cnt_mode);

  mcyc_seq #(.MC_LEN(MC_LEN), .SMP_PH(SMP_PH), .INC_PH(INC_PH)) u_seq (
    .clk(clk), .rst(rst), .phase(phase), .smp_stb(smp_stb), .inc_stb(inc_stb)
  );

  edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .ext_in(ext_in), .smp_stb(smp_stb), .fall_det(fall_det)
  );

  assign inc = run_en & inc_stb & ((mode == MODE_TIMER) | fall_det);

  count_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .wr_en({wr_hi, wr_lo}),
    .wr_data(wr_data), .clr_ovf(clr_ovf), .cnt(cnt), .ovf(ovf_flag)
  );

  assign cnt_lo = cnt[BYTE_W-1:0];
  assign cnt_hi = cnt[CNT_W-1:BYTE_W];

  // R2/R3: one increment adds exactly one to the full 16-bit value
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_lo && !wr_hi) |=> ({cnt_hi, cnt_lo} == CNT_W'($past({cnt_hi, cnt_lo}) + 1)));
  // R7: stopped counter ignores increments
  p_stopped_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo}));
  // R9: a write cancels an increment in the same cycle
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (cnt_hi == $past(cnt_hi)));
endmodule

// File: tb/tb_evt_timer16.sv
`timescale 1ns/1ps
module tb_evt_timer16;
  localparam int MC = 12, SMP = 9, INCP = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic run_en = 0, cnt_mode = 0, ext_in = 0, wr_lo = 0, wr_hi = 0, clr_ovf = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // model state
  int m_ph = 0, m_cnt = 0;
  bit m_ovf = 0, m_s1 = 0, m_s2 = 0, m_last = 0, m_det = 0;

  always #2.5 clk = ~clk;

  evt_timer16 dut (
    .clk(clk), .rst(rst), .run_en(run_en), .cnt_mode(cnt_mode), .ext_in(ext_in),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_ovf(clr_ovf),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge from the stable inputs
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_ovf = 0; m_s1 = 0; m_s2 = 0; m_last = 0; m_det = 0;
    end else begin
      bit do_inc, set;
      do_inc = run_en && (m_ph == INCP) && (!cnt_mode || m_det);
      set = 0;
      if (wr_lo || wr_hi) begin
        if (wr_lo) m_cnt = (m_cnt & 'hFF00) | wr_data;
        if (wr_hi) m_cnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
      end else if (do_inc) begin
        if (m_cnt == 'hFFFF) set = 1;
        m_cnt = (m_cnt + 1) & 'hFFFF;
      end
      if (set) m_ovf = 1; else if (clr_ovf) m_ovf = 0;
      if (m_ph == SMP) begin
        m_det = m_last && !m_s2;
        m_last = m_s2;
      end
      m_s2 = m_s1; m_s1 = ext_in;
      m_ph = (m_ph == MC - 1) ? 0 : m_ph + 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cnt_hi, cnt_lo} == m_cnt[15:0], "R2/R4 count vs model", {cnt_hi, cnt_lo}, m_cnt);
      chk(ovf_flag == m_ovf, "R8 flag vs model", ovf_flag, m_ovf);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ph(input int p);
    @(negedge clk);
    while (m_ph != p) @(negedge clk);
  endtask

  task automatic write16(input int v);
    wr_lo = 1; wr_hi = 0; wr_data = v[7:0]; step(1);
    wr_lo = 0; wr_hi = 1; wr_data = v[15:8]; step(1);
    wr_hi = 0;
  endtask

  function automatic int cur();
    return {cnt_hi, cnt_lo};
  endfunction

  initial begin
    int base;
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk(cur() == 0, "R1 count after reset", cur(), 0);
    chk(ovf_flag == 0, "R1 flag after reset", ovf_flag, 0);
    chk(m_ph == 1, "R1 phase start", m_ph, 1);

    // R7 stopped: no change
    step(40);
    chk(cur() == 0, "R7 hold while stopped", cur(), 0);

    // R2 timer rate
    run_en = 1; base = cur(); step(120);
    chk(cur() == base + 10, "R2 ten steps in 120 clocks", cur(), base + 10);

    // R3 carry into high byte
    run_en = 0; write16('h00FF); run_en = 1; step(12);
    chk(cur() == 'h0100, "R3 carry", cur(), 'h0100);

    // R7 stop in timer mode
    run_en = 0; base = cur(); step(60);
    chk(cur() == base, "R7 hold timer", cur(), base);

    // R8 overflow
    write16('hFFFF); run_en = 1; step(12);
    chk(cur() == 0, "R8 wrap to zero", cur(), 0);
    chk(ovf_flag == 1, "R8 flag set", ovf_flag, 1);
    step(30);
    chk(ovf_flag == 1, "R8 flag sticky", ovf_flag, 1);
    clr_ovf = 1; step(1); clr_ovf = 0; step(1);
    chk(ovf_flag == 0, "R8 flag cleared", ovf_flag, 0);

    // R8 set beats clear in the same cycle
    run_en = 0; write16('hFFFF); run_en = 1;
    wait_ph(INCP); clr_ovf = 1; step(1); clr_ovf = 0;
    chk(ovf_flag == 1, "R8 set wins over clear", ovf_flag, 1);
    clr_ovf = 1; step(1); clr_ovf = 0;

    // R9 write collides with increment
    run_en = 0; write16('h1234); run_en = 1;
    wait_ph(INCP); wr_lo = 1; wr_data = 8'h80; step(1); wr_lo = 0;
    chk(cur() == 'h1280, "R9 write beats increment", cur(), 'h1280);
    wait_ph(INCP); wr_hi = 1; wr_data = 8'h55; step(1); wr_hi = 0;
    chk(cur() == 'h5580, "R9 high write keeps low byte", cur(), 'h5580);

    // R4 event counting: 5 falling edges, 48-clock period
    run_en = 0; write16(0); cnt_mode = 1; ext_in = 0; run_en = 1; step(40);
    chk(cur() == 0, "R6 steady low no counts", cur(), 0);
    for (int k = 0; k < 5; k++) begin
      ext_in = 1; step(24); ext_in = 0; step(24);
    end
    step(36);
    chk(cur() == 5, "R4 five edges counted", cur(), 5);

    // R5 lag: count appears only in the following machine cycle
    wait_ph(SMP + 1); ext_in = 1; step(12); ext_in = 0;
    base = cur();
    wait_ph(SMP + 1);
    chk(cur() == base, "R5 no count in detecting cycle", cur(), base);
    step(12);
    chk(cur() == base + 1, "R5 count next cycle", cur(), base + 1);

    // R6 short pulse between samples
    step(24); base = cur();
    wait_ph(SMP + 1); ext_in = 1; step(4); ext_in = 0; step(48);
    chk(cur() == base, "R6 missed pulse ignored", cur(), base);

    // R7 stopped in event mode
    run_en = 0; base = cur();
    for (int k = 0; k < 3; k++) begin
      ext_in = 1; step(24); ext_in = 0; step(24);
    end
    chk(cur() == base, "R7 hold event mode", cur(), base);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule